// File: doc/BRIEF.md
# eBPF Integer ALU

This block is the integer execution unit of a kernel-bytecode processor. In one clock it combines a destination register value with a second operand and returns the new destination value. The second operand is either the source register value or a sign-extended 32-bit immediate. The caller supplies the operation code that the decoder has already extracted. It also supplies a flag that picks 64-bit or 32-bit arithmetic, and the source-select bit taken from the instruction.

Fourteen operations are supported:

- the arithmetic and logic group: add, subtract, multiply, unsigned divide, unsigned remainder, or, and, xor, move and negate;
- three shifts;
- a byte-order conversion whose width comes from the immediate.

An operation code or conversion width that is not defined raises an illegal flag, and the destination value is passed through unchanged. The result, a valid strobe and the illegal flag are registered, so they appear one cycle after the request. They hold their values while no request is presented.

Top module: `ebpf_int_alu`

## Requirements
- R1: Operation codes are ADD=0, SUB=1, MUL=2, DIV=3, OR=4, AND=5, LSH=6, RSH=7, NEG=8, MOD=9, XOR=0xA, MOV=0xB, ARSH=0xC, END=0xD. With `wide_i`=1, ADD, SUB, MUL, OR, AND and XOR produce the 64-bit two's-complement result (the low 64 bits of the product for MUL), wrapping on overflow.
- R2: The second operand is `src_val_i` when `src_sel_i`=1. When `src_sel_i`=0 it is `imm_i` sign-extended to 64 bits. MOV returns that operand.
- R3: With `wide_i`=0, operations 0x0 to 0xC use only bits 31:0 of both operands, and the 32-bit result is zero-extended into bits 63:32.
- R4: NEG returns the two's-complement negation of the destination value at the selected width. It gives the same result whatever the values of `src_val_i`, `imm_i` and `src_sel_i`.
- R5: LSH and RSH take the shift amount from the second operand. The amount is masked to 6 bits in 64-bit mode and to 5 bits in 32-bit mode. RSH fills with zeros.
- R6: ARSH fills with copies of the sign bit of the operand width (bit 63 or bit 31). The 32-bit result is then zero-extended.
- R7: DIV and MOD are unsigned. A zero divisor makes DIV return 0 and makes MOD return the destination value, which is its low 32 bits zero-extended in 32-bit mode.
- R8: END with `src_sel_i`=0 and `imm_i` equal to 16, 32 or 64 returns the low `imm_i` bits of the destination, zero-extended, whatever the value of `wide_i`.
- R9: END with `src_sel_i`=1 and `imm_i` equal to 16, 32 or 64 reverses the byte order within the low `imm_i` bits of the destination and zero-extends the result.
- R10: END with any other `imm_i`, and the operation codes 0xE and 0xF, set `illegal_o`=1 and return the destination value unchanged. All other requests clear `illegal_o`.
- R11: `valid_o`, `result_o` and `illegal_o` reflect a request one clock after `valid_i`=1. While `valid_i`=0, `valid_o` is 0 and `result_o` and `illegal_o` hold their values.
- R12: While `rst_ni` is low, `valid_o`, `result_o` and `illegal_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 selects 64-bit, 0 selects 32-bit arithmetic |
| src_sel_i | input | 1 | Operand select; for END, 1 selects byte reversal |
| dst_val_i | input | DATA_W | Destination register value |
| src_val_i | input | DATA_W | Source register value |
| imm_i | input | IMM_W | Immediate; for END it gives the width |
| valid_o | output | 1 | Result strobe |
| result_o | output | DATA_W | New destination value |
| illegal_o | output | 1 | Undefined operation or conversion width |

## Verification
The bench builds the block with its default widths: a 64-bit datapath and a 32-bit immediate. These widths give the real split between the 64-bit and 32-bit classes. They also make every conversion width (16, 32 and 64) legal within the datapath, so the zero-extension boundary at bit 32, the masking of shift counts at 6 and 5 bits, and sign extension of negative immediates are all exercised. A behavioural model in the bench predicts the outputs on every clock, including the division-by-zero cases and the hold behaviour while no request is presented.

// File: rtl/ebpf_alu_pkg.sv
package ebpf_alu_pkg;
  typedef enum logic [3:0] {
    ALU_ADD  = 4'h0,
    ALU_SUB  = 4'h1,
    ALU_MUL  = 4'h2,
    ALU_DIV  = 4'h3,
    ALU_OR   = 4'h4,
    ALU_AND  = 4'h5,
    ALU_LSH  = 4'h6,
    ALU_RSH  = 4'h7,
    ALU_NEG  = 4'h8,
    ALU_MOD  = 4'h9,
    ALU_XOR  = 4'hA,
    ALU_MOV  = 4'hB,
    ALU_ARSH = 4'hC,
    ALU_END  = 4'hD
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_LOGIC = 2'd1,
    SH_ARITH = 2'd2
  } shift_kind_e;

  localparam int unsigned N_END_W = 3;  // conversion widths 16, 32, 64
endpackage

// File: rtl/ebpf_alu_shift.sv
module ebpf_alu_shift
  import ebpf_alu_pkg::*;
#(
  parameter int W = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [AW-1:0] amt_i,
  input  shift_kind_e   kind_i,
  output logic [W-1:0]  res_o
);
  always_comb begin
    case (kind_i)
      SH_LEFT:  res_o = val_i << amt_i;
      SH_LOGIC: res_o = val_i >> amt_i;
      default:  res_o = W'($signed(val_i) >>> amt_i);
    endcase
  end
endmodule

// File: rtl/ebpf_alu_divmod.sv
module ebpf_alu_divmod #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic zero_div;
  assign zero_div = (b_i == '0);
  assign quo_o = zero_div ? '0  : a_i / b_i;
  assign rem_o = zero_div ? a_i : a_i % b_i;
endmodule

// File: rtl/ebpf_alu_byteswap.sv
module ebpf_alu_byteswap #(
  parameter int W = 64,
  localparam int NB = W / 8
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] swp_o
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign swp_o[8*i +: 8] = val_i[W-8-8*i +: 8];
  end
endmodule

// File: rtl/ebpf_int_alu.sv
module ebpf_int_alu
  import ebpf_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              wide_i,
  input  logic              src_sel_i,
  input  logic [DATA_W-1:0] dst_val_i,
  input  logic [DATA_W-1:0] src_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int SH_F   = $clog2(DATA_W);
  localparam int SH_H   = $clog2(HALF_W);
  localparam int IDX_W  = $clog2(N_END_W);

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [DATA_W-1:0] a_f, b_f;
  logic [HALF_W-1:0] a_h, b_h;
  assign a_f = dst_val_i;
  assign b_f = src_sel_i ? src_val_i
                         : {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign a_h = a_f[HALF_W-1:0];
  assign b_h = b_f[HALF_W-1:0];

  shift_kind_e sh_kind;
  always_comb begin
    case (op)
      ALU_LSH: sh_kind = SH_LEFT;
      ALU_RSH: sh_kind = SH_LOGIC;
      default: sh_kind = SH_ARITH;
    endcase
  end

  logic [DATA_W-1:0] sh_f, quo_f, rem_f;
  logic [HALF_W-1:0] sh_h, quo_h, rem_h;

  ebpf_alu_shift #(.W(DATA_W)) u_sh_f (
    .val_i(a_f), .amt_i(b_f[SH_F-1:0]), .kind_i(sh_kind), .res_o(sh_f)
  );
  ebpf_alu_shift #(.W(HALF_W)) u_sh_h (
    .val_i(a_h), .amt_i(b_h[SH_H-1:0]), .kind_i(sh_kind), .res_o(sh_h)
  );
  ebpf_alu_divmod #(.W(DATA_W)) u_dm_f (
    .a_i(a_f), .b_i(b_f), .quo_o(quo_f), .rem_o(rem_f)
  );
  ebpf_alu_divmod #(.W(HALF_W)) u_dm_h (
    .a_i(a_h), .b_i(b_h), .quo_o(quo_h), .rem_o(rem_h)
  );

  // byte-order conversion, one lane per width 16 << k
  logic [DATA_W-1:0] end_le [N_END_W];
  logic [DATA_W-1:0] end_be [N_END_W];
  for (genvar k = 0; k < N_END_W; k++) begin : g_end
    localparam int EW = 16 << k;
    logic [EW-1:0] swp;
    ebpf_alu_byteswap #(.W(EW)) u_swap (
      .val_i(dst_val_i[EW-1:0]), .swp_o(swp)
    );
    assign end_le[k] = DATA_W'(dst_val_i[EW-1:0]);
    assign end_be[k] = DATA_W'(swp);
  end

  logic             end_ok;
  logic [IDX_W-1:0] end_idx;
  always_comb begin
    end_ok  = 1'b1;
    end_idx = '0;
    case (imm_i)
      IMM_W'(16): end_idx = IDX_W'(0);
      IMM_W'(32): end_idx = IDX_W'(1);
      IMM_W'(64): end_idx = IDX_W'(2);
      default:    end_ok  = 1'b0;
    endcase
  end

  logic [DATA_W-1:0] r_f, nxt_res;
  logic [HALF_W-1:0] r_h;
  logic              nxt_ill;

  always_comb begin
    case (op)
      ALU_ADD:  begin r_f = a_f + b_f;  r_h = a_h + b_h;  end
      ALU_SUB:  begin r_f = a_f - b_f;  r_h = a_h - b_h;  end
      ALU_MUL:  begin r_f = a_f * b_f;  r_h = a_h * b_h;  end
      ALU_DIV:  begin r_f = quo_f;      r_h = quo_h;      end
      ALU_OR:   begin r_f = a_f | b_f;  r_h = a_h | b_h;  end
      ALU_AND:  begin r_f = a_f & b_f;  r_h = a_h & b_h;  end
      ALU_LSH,
      ALU_RSH,
      ALU_ARSH: begin r_f = sh_f;       r_h = sh_h;       end
      ALU_NEG:  begin r_f = -a_f;       r_h = -a_h;       end
      ALU_MOD:  begin r_f = rem_f;      r_h = rem_h;      end
      ALU_XOR:  begin r_f = a_f ^ b_f;  r_h = a_h ^ b_h;  end
      ALU_MOV:  begin r_f = b_f;        r_h = b_h;        end
      default:  begin r_f = a_f;        r_h = a_h;        end
    endcase

    if (op_i == ALU_END) begin
      nxt_ill = !end_ok;
      if (!end_ok)        nxt_res = dst_val_i;
      else if (src_sel_i) nxt_res = end_be[end_idx];
      else                nxt_res = end_le[end_idx];
    end else if (op_i > ALU_END) begin
      nxt_ill = 1'b1;
      nxt_res = dst_val_i;
    end else begin
      nxt_ill = 1'b0;
      nxt_res = wide_i ? r_f : DATA_W'(r_h);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= nxt_res;
        illegal_o <= nxt_ill;
      end
    end
  end
endmodule

// File: rtl/ebpf_alu_chk.sv
module ebpf_alu_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              wide_i,
  input logic              src_sel_i,
  input logic [DATA_W-1:0] dst_val_i,
  input logic [DATA_W-1:0] src_val_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);
  localparam int HALF_W = DATA_W / 2;

  logic bad_width;
  assign bad_width = (imm_i != IMM_W'(16)) && (imm_i != IMM_W'(32)) &&
                     (imm_i != IMM_W'(64));

  assert_valid_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  assert_hold_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(illegal_o));

  assert_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i && op_i < 4'hD |=> result_o[DATA_W-1:HALF_W] == '0);

  assert_neg_wide_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_i && op_i == 4'h8 |=> result_o == -$past(dst_val_i));

  assert_div_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'h3 && src_sel_i && src_val_i == '0 |=> result_o == '0);

  assert_mod_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_i && op_i == 4'h9 && src_sel_i && src_val_i == '0
      |=> result_o == $past(dst_val_i));

  assert_end_bad_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'hD && bad_width |=> illegal_o && result_o == $past(dst_val_i));

  assert_legal_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i < 4'hD |=> !illegal_o);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_R12: assert (!valid_o && result_o == '0 && !illegal_o);
    end
  end
endmodule

bind ebpf_int_alu ebpf_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/tb_ebpf_int_alu.sv
module tb_ebpf_int_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        wide_i = 1'b0;
  logic        src_sel_i = 1'b0;
  logic [63:0] dst_val_i = '0;
  logic [63:0] src_val_i = '0;
  logic [31:0] imm_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ebpf_int_alu dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .wide_i(wide_i), .src_sel_i(src_sel_i), .dst_val_i(dst_val_i),
    .src_val_i(src_val_i), .imm_i(imm_i), .valid_o(valid_o),
    .result_o(result_o), .illegal_o(illegal_o)
  );

  // expectation for the output after the next edge
  bit          pend = 1'b0;
  logic        e_val;
  logic [63:0] e_res = '0;
  logic        e_ill = 1'b0;
  string       e_tag;

  function automatic logic [63:0] calc64(int op, logic [63:0] a, logic [63:0] b);
    case (op)
      0:  return a + b;
      1:  return a - b;
      2:  return a * b;
      3:  return (b == 0) ? 64'd0 : a / b;
      4:  return a | b;
      5:  return a & b;
      6:  return a << b[5:0];
      7:  return a >> b[5:0];
      8:  return 64'd0 - a;
      9:  return (b == 0) ? a : a % b;
      10: return a ^ b;
      11: return b;
      default: return 64'($signed(a) >>> b[5:0]);
    endcase
  endfunction

  function automatic logic [31:0] calc32(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      0:  return a + b;
      1:  return a - b;
      2:  return a * b;
      3:  return (b == 0) ? 32'd0 : a / b;
      4:  return a | b;
      5:  return a & b;
      6:  return a << b[4:0];
      7:  return a >> b[4:0];
      8:  return 32'd0 - a;
      9:  return (b == 0) ? a : a % b;
      10: return a ^ b;
      11: return b;
      default: return 32'($signed(a) >>> b[4:0]);
    endcase
  endfunction

  task automatic model(int op, bit wide, bit sel, logic [63:0] dst,
                       logic [63:0] src, logic [31:0] imm);
    logic [63:0] b = sel ? src : {{32{imm[31]}}, imm};
    e_val = 1'b1;
    if (op == 13) begin
      int w = int'(imm);
      if (imm == 16 || imm == 32 || imm == 64) begin
        e_ill = 1'b0;
        e_res = '0;
        for (int i = 0; i < w / 8; i++)
          e_res[8*i +: 8] = sel ? dst[8*(w/8-1-i) +: 8] : dst[8*i +: 8];
        e_tag = sel ? "R9" : "R8";
      end else begin
        e_ill = 1'b1; e_res = dst; e_tag = "R10";
      end
    end else if (op > 13) begin
      e_ill = 1'b1; e_res = dst; e_tag = "R10";
    end else begin
      e_ill = 1'b0;
      e_res = wide ? calc64(op, dst, b) : {32'd0, calc32(op, dst[31:0], b[31:0])};
      if (op == 8)                   e_tag = "R4";
      else if (op == 6 || op == 7)   e_tag = "R5";
      else if (op == 12)             e_tag = "R6";
      else if (op == 3 || op == 9)   e_tag = "R7";
      else if (op == 11)             e_tag = "R2";
      else if (!wide)                e_tag = "R3";
      else                           e_tag = "R1";
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      checks++;
      if (valid_o !== e_val || result_o !== e_res || illegal_o !== e_ill) begin
        errors++;
        $display("FAIL %s actual v=%0b r=%h i=%0b expected v=%0b r=%h i=%0b",
                 e_tag, valid_o, result_o, illegal_o, e_val, e_res, e_ill);
      end
    end
  endtask

  task automatic do_op(int op, bit wide, bit sel, logic [63:0] dst,
                       logic [63:0] src, logic [31:0] imm);
    @(negedge clk);
    check_pending();
    valid_i = 1'b1; op_i = 4'(op); wide_i = wide; src_sel_i = sel;
    dst_val_i = dst; src_val_i = src; imm_i = imm;
    model(op, wide, sel, dst, src, imm);
    pend = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    check_pending();
    valid_i = 1'b0;
    op_i = 4'h1; dst_val_i = 64'h5A5A_5A5A_5A5A_5A5A; src_val_i = 64'h1; imm_i = 32'h40;
    e_val = 1'b0; e_tag = "R11";  // result and illegal held
    pend = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || result_o !== 64'd0 || illegal_o !== 1'b0) begin
      errors++;
      $display("FAIL R12 actual v=%0b r=%h i=%0b expected v=0 r=0 i=0",
               valid_o, result_o, illegal_o);
    end
    rst_ni = 1'b1;

    // R1 wide arithmetic and logic
    do_op(0,  1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0);
    do_op(1,  1, 0, 64'd5, 64'd0, 32'd7);
    do_op(2,  1, 1, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 32'd0);
    do_op(4,  1, 1, 64'hF0F0_0000_0000_000F, 64'h0F00_0000_0000_00F0, 32'd0);
    do_op(5,  1, 0, 64'hFFFF_FFFF_1234_5678, 64'd0, 32'hFFFF_FF00);
    do_op(10, 1, 1, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000, 32'd0);
    // R2 operand select and sign extension
    do_op(11, 1, 0, 64'd1, 64'h1234, 32'hFFFF_FF80);
    do_op(11, 1, 1, 64'd1, 64'hCAFE_F00D_0000_0001, 32'h7);
    do_op(11, 0, 0, 64'd1, 64'd0, 32'hFFFF_FF80);
    // R3 32-bit class
    do_op(0,  0, 0, 64'hDEAD_BEEF_FFFF_FFFF, 64'd0, 32'd1);
    do_op(2,  0, 1, 64'h1111_1111_0001_0000, 64'h2222_2222_0001_0000, 32'd0);
    do_op(1,  0, 1, 64'h0, 64'h0, 32'd0);
    // R4 negate ignores second operand
    do_op(8,  1, 0, 64'd5, 64'h1234, 32'h7777_7777);
    do_op(8,  1, 1, 64'd5, 64'hFFFF_0000_0000_0001, 32'h0);
    do_op(8,  0, 0, 64'h1234_5678_0000_0001, 64'd9, 32'd3);
    // R5 shifts with masking
    do_op(6,  1, 1, 64'h8000_0000_0000_0001, 64'd65, 32'd0);
    do_op(6,  0, 0, 64'h0000_0000_4000_0001, 64'd0, 32'd33);
    do_op(7,  1, 0, 64'h8000_0000_0000_0000, 64'd0, 32'd63);
    do_op(7,  0, 1, 64'hFFFF_FFFF_8000_0000, 64'd31, 32'd0);
    // R6 arithmetic shift
    do_op(12, 1, 0, 64'hF000_0000_0000_0010, 64'd0, 32'd4);
    do_op(12, 0, 0, 64'h0000_0000_8000_0000, 64'd0, 32'd31);
    do_op(12, 0, 1, 64'hFFFF_FFFF_7000_0000, 64'd4, 32'd0);
    // R7 divide and remainder
    do_op(3,  1, 1, 64'd100, 64'd7, 32'd0);
    do_op(3,  1, 1, 64'd100, 64'd0, 32'd0);
    do_op(3,  0, 1, 64'hFFFF_0000_0000_0064, 64'hFFFF_FFFF_0000_0000, 32'd0);
    do_op(9,  1, 1, 64'd100, 64'd7, 32'd0);
    do_op(9,  1, 1, 64'hDEAD_0000_0000_1234, 64'd0, 32'd0);
    do_op(9,  0, 0, 64'hDEAD_0000_0000_1234, 64'd0, 32'd0);
    // R11 hold while idle
    idle();
    idle();
    // R8 / R9 byte order
    do_op(13, 0, 0, 64'h0123_4567_89AB_CDEF, 64'd0, 32'd16);
    do_op(13, 1, 0, 64'h0123_4567_89AB_CDEF, 64'd0, 32'd32);
    do_op(13, 0, 0, 64'h0123_4567_89AB_CDEF, 64'd0, 32'd64);
    do_op(13, 0, 1, 64'h0123_4567_89AB_CDEF, 64'd0, 32'd16);
    do_op(13, 1, 1, 64'h0123_4567_89AB_CDEF, 64'd0, 32'd32);
    do_op(13, 0, 1, 64'h0123_4567_89AB_CDEF, 64'd0, 32'd64);
    // R10 illegal cases, then clear
    do_op(13, 1, 1, 64'h0123_4567_89AB_CDEF, 64'd0, 32'd8);
    idle();
    do_op(14, 1, 1, 64'h5555_6666_7777_8888, 64'd1, 32'd0);
    do_op(15, 0, 0, 64'h1, 64'd1, 32'd0);
    do_op(0,  1, 1, 64'd2, 64'd3, 32'd0);
    idle();
    @(negedge clk);
    check_pending();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule